// File: doc/BRIEF.md
# Sleep and Hold Gating Controller

This block sits between the serial-peripheral pins and the command engine of a serial memory. It works in the system clock domain, on serial clock, chip-select, data-in and pause-request levels that have already been synchronised. It decides when the command engine may see serial activity. It hands the engine a one-cycle enable for each rising serial-clock edge, a registered copy of chip select, and a permission for the data output driver. A ready flag reports whether the block is fully awake.

The block reads the first byte of every transaction. If that byte is the sleep opcode and chip select is then released, the block goes to sleep. While asleep, all serial activity is blocked and the output driver is forced off. The next falling edge of chip select starts a recovery period of a set number of system-clock cycles. The transaction in flight during that wake-up is discarded, and a fresh chip-select cycle is needed before commands are accepted again. An active-low pause input freezes a transfer in place without aborting it. It takes effect only while the serial clock is low.

Top module: `sleep_hold_gate`

## Requirements
- R1: After reset `ready` is 1, `cs_n_out` is 1 and, with `cs_n` high, `q_oe_allow` is 0.
- R2: When the first 8 serial bits of a transaction, sampled MSB first on rising `sck`, equal 0xB9 and `cs_n` then rises, `ready` is 0 one system-clock cycle after the rise is sampled.
- R3: A transaction whose first byte is not 0xB9, or one that ends before 8 bits, leaves `ready` at 1.
- R4: While asleep, `sck_rise_en` and `q_oe_allow` stay 0 and `cs_n_out` stays 1, whatever `sck`, `mosi` or `cs_n` do.
- R5: A falling `cs_n` while asleep starts recovery. `ready` returns to 1 exactly WAKE_CYCLES system-clock cycles after the cycle that samples the fall, and outputs stay blocked until then.
- R6: After recovery, the transaction that woke the block stays blocked (`cs_n_out` 1, no `sck_rise_en`, `q_oe_allow` 0) until `cs_n` goes high. The next transaction passes normally.
- R7: `hold_n` low while `sck` is low pauses the transfer from the next cycle. `sck_rise_en` and `q_oe_allow` are 0, and `cs_n_out` is frozen even if `cs_n` moves. Releasing `hold_n` while `sck` is low resumes the transfer with its bit count intact.
- R8: A change of `hold_n` while `sck` is high has no effect until `sck` is next low.
- R9: When awake and not paused, `cs_n_out` follows `cs_n` one cycle later, `q_oe_allow` equals the inverse of `cs_n`, and `sck_rise_en` pulses once per sampled `sck` rise while `cs_n` is low.
- R10: Bits after the first 8 of a transaction do not alter the captured opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Synchronised serial clock level |
| cs_n | input | 1 | Synchronised active-low chip select |
| mosi | input | 1 | Synchronised serial data in |
| hold_n | input | 1 | Active-low pause request |
| sck_rise_en | output | 1 | One-cycle enable per accepted serial-clock rise |
| cs_n_out | output | 1 | Gated, registered chip select for the command engine |
| q_oe_allow | output | 1 | 1 permits the data output driver, 0 forces high impedance |
| ready | output | 1 | 1 when awake and recovery is complete |

## Verification
The bench measures the recovery window to the exact cycle. A timer off by one would raise `ready` a cycle early or late. It sends a sleep opcode cut short by one bit, and one with extra bytes after it. A capture that counted too few bits, or kept shifting past eight, would get these wrong. It splits a sleep opcode with a pause that carries serial clocks and a chip-select glitch. A pause that leaked edges would corrupt the opcode, and one that let chip select through would abort the transfer. It also lowers and raises the pause input while the serial clock is high, and it keeps chip select low after wake-up. A design that gated on the raw pause level, or that handed the engine a chip select falling in mid-transaction, would fail these checks.

// File: rtl/sgh_pkg.sv
package sgh_pkg;

    typedef enum logic [1:0] {
        M_AWAKE  = 2'd0,
        M_ASLEEP = 2'd1,
        M_WAKING = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  held;
        logic  void_txn;
        logic  cs_prev;
        logic  sck_prev;
        logic  cs_out;
    } gate_state_t;

endpackage

// File: rtl/sgh_op_capture.sv
module sgh_op_capture #(
    parameter int               OPW   = 8,
    parameter logic [OPW-1:0]   MATCH = 8'hB9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_in,
    output logic match
);
    localparam int CW = $clog2(OPW + 1);
    localparam logic [CW-1:0] FULL = CW'(OPW);

    logic [OPW-1:0] sh_d, sh_q;
    logic [CW-1:0]  cnt_d, cnt_q;

    always_comb begin
        sh_d  = sh_q;
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (shift_en && cnt_q != FULL) begin
            sh_d  = {sh_q[OPW-2:0], bit_in};
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            sh_q  <= sh_d;
            cnt_q <= cnt_d;
        end
    end

    assign match = (cnt_q == FULL) && (sh_q == MATCH);

    // R10: a full byte is never disturbed by later bits
    a_r10_freeze_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL && !clear) |=> $stable(sh_q));

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

endmodule

// File: rtl/sgh_wake_timer.sv
module sgh_wake_timer #(
    parameter int CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] START = CW'(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = START;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q == CW'(1));

    // R5: recovery always starts from the full count and never underflows
    a_r5_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == START);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q != '0);

endmodule

// File: rtl/sleep_hold_gate.sv
module sleep_hold_gate #(
    parameter int             OPCODE_W     = 8,
    parameter logic [7:0]     SLEEP_OPCODE = 8'hB9,
    parameter int             WAKE_CYCLES  = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic hold_n,
    output logic sck_rise_en,
    output logic cs_n_out,
    output logic q_oe_allow,
    output logic ready
);
    import sgh_pkg::*;

    gate_state_t s_d, s_q;
    logic sck_rise, cs_fall, cs_rise, live, awake;
    logic op_match, cap_clear, wake_load, wake_run, wake_expire;

    assign awake    = (s_q.mode == M_AWAKE);
    assign live     = awake && !s_q.void_txn && !s_q.held;
    assign sck_rise = sck && !s_q.sck_prev;
    assign cs_fall  = s_q.cs_prev && !cs_n;
    assign cs_rise  = !s_q.cs_prev && cs_n;

    assign wake_load = (s_q.mode == M_ASLEEP) && cs_fall;
    assign wake_run  = (s_q.mode == M_WAKING);
    assign cap_clear = (live && cs_fall) || wake_load;

    sgh_op_capture #(.OPW(OPCODE_W), .MATCH(SLEEP_OPCODE[OPCODE_W-1:0])) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cap_clear),
        .shift_en (sck_rise_en),
        .bit_in   (mosi),
        .match    (op_match)
    );

    sgh_wake_timer #(.CYCLES(WAKE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wake_load),
        .run    (wake_run),
        .expire (wake_expire)
    );

    always_comb begin
        s_d          = s_q;
        s_d.sck_prev = sck;
        // chip-select edges are deferred while paused
        s_d.cs_prev  = (awake && s_q.held) ? s_q.cs_prev : cs_n;

        unique case (s_q.mode)
            M_AWAKE:  if (live && cs_rise && op_match) s_d.mode = M_ASLEEP;
            M_ASLEEP: if (wake_load)                   s_d.mode = M_WAKING;
            M_WAKING: if (wake_expire)                 s_d.mode = M_AWAKE;
            default:                                   s_d.mode = M_AWAKE;
        endcase

        if (wake_load)
            s_d.void_txn = 1'b1;
        else if (awake && cs_n)
            s_d.void_txn = 1'b0;

        if (s_d.mode != M_AWAKE)
            s_d.held = 1'b0;
        else if (!sck)
            s_d.held = !hold_n;

        if (awake && s_q.held)
            s_d.cs_out = s_q.cs_out;
        else if (!awake || s_q.void_txn)
            s_d.cs_out = 1'b1;
        else
            s_d.cs_out = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode     <= M_AWAKE;
            s_q.held     <= 1'b0;
            s_q.void_txn <= 1'b0;
            s_q.cs_prev  <= 1'b1;
            s_q.sck_prev <= 1'b0;
            s_q.cs_out   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sck_rise_en = live && !cs_n && sck_rise;
    assign q_oe_allow  = live && !cs_n;
    assign cs_n_out    = s_q.cs_out;
    assign ready       = awake;

    // R2: completed sleep opcode plus chip-select rise drops ready
    a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cs_rise && op_match) |=> !ready);

    // R4: not ready means everything toward the engine is blocked
    a_r4_quiet_when_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!q_oe_allow && !sck_rise_en && cs_n_out));

    // R7: chip select seen by the engine is frozen during a pause
    a_r7_cs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.held && $past(s_q.held)) |-> $stable(cs_n_out));

    // R8: the pause state only changes after a cycle with sck low
    a_r8_hold_on_low_sck: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(awake) && awake && (s_q.held != $past(s_q.held))) |-> !$past(sck));

endmodule

// File: tb/sleep_hold_gate_bench.sv
module sleep_hold_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
    logic sck_rise_en, cs_n_out, q_oe_allow, ready;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_hold_gate #(.WAKE_CYCLES(W)) u_sleep_hold_gate (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .hold_n(hold_n), .sck_rise_en(sck_rise_en), .cs_n_out(cs_n_out),
        .q_oe_allow(q_oe_allow), .ready(ready)
    );

    always @(posedge clk) if (sck_rise_en) pulses <= pulses + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        mosi = b; sck = 1'b0;
        @(negedge clk);
        sck = 1'b1;
        @(negedge clk);
        sck = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk); cs_n = v; @(negedge clk);
    endtask

    task automatic wake_up;
        set_cs(1'b0);
        repeat (W + 2) @(negedge clk);
        set_cs(1'b1);
    endtask

    task automatic t_reset;
        check("R1 ready", ready, 1);
        check("R1 cs_n_out", cs_n_out, 1);
        check("R1 q_oe_allow", q_oe_allow, 0);
    endtask

    task automatic t_passthru;
        int p;
        set_cs(1'b0);
        check("R9 cs_n_out follows", cs_n_out, 0);
        check("R9 q_oe_allow", q_oe_allow, 1);
        p = pulses;
        send_byte(8'h03);
        check("R9 edge pulses", pulses - p, 8);
        set_cs(1'b1);
        check("R9 cs_n_out high", cs_n_out, 1);
        check("R3 other opcode keeps ready", ready, 1);
    endtask

    task automatic t_short;
        set_cs(1'b0);
        for (int i = 7; i >= 1; i--) send_bit(logic'(8'hB9 >> i));
        set_cs(1'b1);
        check("R3 seven bits keep ready", ready, 1);
    endtask

    task automatic t_sleep_wake;
        int p;
        set_cs(1'b0);
        send_byte(8'hB9);
        set_cs(1'b1);
        check("R2 ready low after sleep", ready, 0);
        p = pulses;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        check("R4 no edges asleep", pulses - p, 0);
        check("R4 cs_n_out high asleep", cs_n_out, 1);
        @(negedge clk); cs_n = 1'b0; #1;
        check("R4 q_oe off asleep", q_oe_allow, 0);
        repeat (W) @(posedge clk);
        @(negedge clk);
        check("R5 ready low before window end", ready, 0);
        check("R5 cs_n_out blocked waking", cs_n_out, 1);
        @(posedge clk); @(negedge clk);
        check("R5 ready exactly at window end", ready, 1);
        check("R6 cs_n_out blocked after wake", cs_n_out, 1);
        check("R6 q_oe blocked after wake", q_oe_allow, 0);
        p = pulses;
        send_bit(1'b0);
        check("R6 edges blocked after wake", pulses - p, 0);
        set_cs(1'b1);
        set_cs(1'b0);
        check("R6 new txn cs_n_out", cs_n_out, 0);
        check("R6 new txn q_oe", q_oe_allow, 1);
        send_byte(8'h00);
        set_cs(1'b1);
        check("R6 still ready", ready, 1);
    endtask

    task automatic t_extra;
        set_cs(1'b0);
        send_byte(8'hB9);
        send_byte(8'hFF);
        set_cs(1'b1);
        check("R10 extra bits ignored", ready, 0);
        wake_up();
        check("R10 woke again", ready, 1);
    endtask

    task automatic t_hold;
        int p;
        set_cs(1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        @(negedge clk); hold_n = 1'b0;
        @(negedge clk);
        check("R7 q_oe off held", q_oe_allow, 0);
        p = pulses;
        @(negedge clk); cs_n = 1'b1;
        send_bit(1'b0); send_bit(1'b0);
        check("R7 no edges held", pulses - p, 0);
        check("R7 cs_n_out frozen", cs_n_out, 0);
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); hold_n = 1'b1;
        @(negedge clk);
        check("R7 q_oe back on", q_oe_allow, 1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        set_cs(1'b1);
        check("R7 split opcode still sleeps", ready, 0);
        wake_up();
    endtask

    task automatic t_hold_high;
        set_cs(1'b0);
        @(negedge clk); sck = 1'b1;
        @(negedge clk); hold_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 hold deferred while sck high", q_oe_allow, 1);
        sck = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R8 hold applies when sck low", q_oe_allow, 0);
        sck = 1'b1;
        @(negedge clk); hold_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 release deferred while sck high", q_oe_allow, 0);
        sck = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R8 release applies when sck low", q_oe_allow, 1);
        set_cs(1'b1);
        check("R8 no sleep", ready, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_short();
        t_sleep_wake();
        t_extra();
        t_hold();
        t_hold_high();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule